// File: doc/BRIEF.md
# Throttle Ratio Search Engine

This block finds the best pair of slot counts for a clock-gating throttle. A throttle period is split into "run" slots (OFF count, core clock running) and "stalled" slots (ON count, core clock stopped). The effective speed is the full-speed frequency scaled by OFF over the period length. Given a requested frequency and the full-speed frequency, both in kHz, and a largest allowed period length, the engine tries every period length from that largest value down to one. For each it derives a candidate pair, computes the frequency the pair really gives, and keeps the candidate whose error to the request is smallest.

All arithmetic runs on one shared restoring divider that yields one quotient bit per cycle. Each candidate takes two divisions, so a search over a full 255-slot range takes about 14,300 cycles. A one-cycle start pulse latches the inputs. Busy stays high while the search runs, and a one-cycle done pulse marks the result outputs valid. The results stay held until the next search. The request must not exceed the full-speed value, and the full-speed value must not be zero.

Top module: `throttle_ratio_search`

## Requirements
- R1: After reset, busy and done are low and the OFF count, ON count and achieved frequency outputs are all zero.
- R2: A start pulse seen while idle latches the request, the full-speed value and the maximum length. When the maximum is nonzero, busy is high from the next cycle until the search ends. Done is high for exactly one cycle, the cycle in which busy falls, and the results are valid from that cycle on.
- R3: For a period length i, the candidate OFF count is floor(request × i / full_speed) kept to its low 8 bits. The candidate ON count is i minus OFF, modulo 256.
- R4: The candidate's achieved frequency is floor(full_speed × OFF / i).
- R5: Period lengths are tried from the maximum down to 1. A candidate replaces the best one when its absolute error to the request is less than or equal to the best error. On a tie the shorter period therefore wins.
- R6: The best starts as OFF=1, ON=0, achieved = full speed. With a maximum length of 0 no candidate is tried, and done pulses one cycle after start with exactly these values.
- R7: A request equal to the full-speed value yields OFF=1, ON=0, achieved = full speed.
- R8: A start pulse that arrives while busy is ignored. The running search completes with the inputs latched at its own start.
- R9: While idle, and with no start, the outputs hold their values whatever the data inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a search (honoured only while idle) |
| req_khz | input | 20 | Requested frequency in kHz |
| full_khz | input | 20 | Full-speed frequency in kHz |
| max_len | input | 8 | Largest period length in slots (0..255) |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse: results valid |
| off_cnt | output | 8 | Chosen run-slot count |
| on_cnt | output | 8 | Chosen stalled-slot count |
| ach_khz | output | 20 | Frequency achieved by the chosen pair |

## Verification
The hardest case to reach is an exact tie in error between two different period lengths, because only the tie rule decides the winner there. The stimulus picks a request at exactly half of full speed with a short maximum. Lengths 4 and 2 then both reach zero error, and the shorter one must be chosen. A second hard case is a start pulse that lands in the middle of a long search while the data inputs change. The bench drives that pulse many cycles after the first start and compares the result against the first input set only.

// File: rtl/throttle_ratio_search.sv
module throttle_ratio_search #(
  parameter int FW = 20,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [FW-1:0] req_khz,
  input  logic [FW-1:0] full_khz,
  input  logic [LW-1:0] max_len,
  output logic          busy,
  output logic          done,
  output logic [LW-1:0] off_cnt,
  output logic [LW-1:0] on_cnt,
  output logic [FW-1:0] ach_khz
);
  localparam int NW = FW + LW;
  localparam int CW = $clog2(NW);

  typedef enum logic [1:0] {S_IDLE, S_DIV1, S_DIV2} st_t;
  st_t st;

  logic [FW-1:0] req_q, full_q, den, rem, best_err;
  logic [LW-1:0] i_q, off_c;
  logic [NW-1:0] num;
  logic [CW-1:0] cnt;

  logic [FW:0]   rem_sh, rem_sub;
  logic          ge, last;
  logic [NW-1:0] quo;
  logic [FW-1:0] f_c, err_c, err0;

  assign busy    = (st != S_IDLE);
  assign rem_sh  = {rem, num[NW-1]};
  assign ge      = rem_sh >= {1'b0, den};
  assign rem_sub = rem_sh - {1'b0, den};
  assign quo     = {num[NW-2:0], ge};
  assign last    = (cnt == CW'(NW-1));
  assign f_c     = quo[FW-1:0];
  assign err_c   = (f_c >= req_q) ? f_c - req_q : req_q - f_c;
  assign err0    = (full_khz >= req_khz) ? full_khz - req_khz : req_khz - full_khz;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; done <= 1'b0;
      off_cnt <= '0; on_cnt <= '0; ach_khz <= '0;
      req_q <= '0; full_q <= '0; den <= '0; rem <= '0; best_err <= '0;
      i_q <= '0; off_c <= '0; num <= '0; cnt <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          req_q <= req_khz; full_q <= full_khz; i_q <= max_len;
          off_cnt <= LW'(1); on_cnt <= '0; ach_khz <= full_khz; best_err <= err0;
          num <= NW'(req_khz) * NW'(max_len);
          den <= full_khz; rem <= '0; cnt <= '0;
          if (max_len == '0) done <= 1'b1;
          else st <= S_DIV1;
        end
        S_DIV1: begin
          num <= quo; rem <= ge ? rem_sub[FW-1:0] : rem_sh[FW-1:0]; cnt <= cnt + 1'b1;
          if (last) begin
            off_c <= quo[LW-1:0];
            num <= NW'(full_q) * NW'(quo[LW-1:0]);
            den <= FW'(i_q); rem <= '0; cnt <= '0;
            st <= S_DIV2;
          end
        end
        S_DIV2: begin
          num <= quo; rem <= ge ? rem_sub[FW-1:0] : rem_sh[FW-1:0]; cnt <= cnt + 1'b1;
          if (last) begin
            if (err_c <= best_err) begin
              off_cnt <= off_c; on_cnt <= i_q - off_c; ach_khz <= f_c; best_err <= err_c;
            end
            rem <= '0; cnt <= '0;
            if (i_q == LW'(1)) begin
              st <= S_IDLE; done <= 1'b1;
            end else begin
              i_q <= i_q - 1'b1;
              num <= NW'(req_q) * NW'(LW'(i_q - 1'b1));
              den <= full_q;
              st <= S_DIV1;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R2: done lasts one cycle
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R2: busy is never seen together with done
  a_r2_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R8: a start while busy does not end or restart the search
  a_r8_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !last |=> busy && $stable(req_q) && $stable(full_q));
  // R9: results held while idle without start
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable({off_cnt, on_cnt, ach_khz}));
  // R6: an empty range returns the initial best
  a_r6_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start && max_len == '0 |=> done && off_cnt == LW'(1) && on_cnt == '0);
endmodule

// File: tb/tb_throttle_ratio_search.sv
module tb_throttle_ratio_search;
  logic clk = 0, rst_n = 0, start = 0;
  logic [19:0] req_khz = 0, full_khz = 0;
  logic [7:0] max_len = 0;
  logic busy, done;
  logic [7:0] off_cnt, on_cnt;
  logic [19:0] ach_khz;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  throttle_ratio_search dut (.clk(clk), .rst_n(rst_n), .start(start), .req_khz(req_khz),
    .full_khz(full_khz), .max_len(max_len), .busy(busy), .done(done),
    .off_cnt(off_cnt), .on_cnt(on_cnt), .ach_khz(ach_khz));

  task automatic chk(string rq, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", rq, act, exp);
    end
  endtask

  task automatic model(longint rq, longint fl, int mx, output longint o, output longint n, output longint f);
    longint be;
    o = 1; n = 0; f = fl;
    be = (fl > rq) ? fl - rq : rq - fl;
    for (int i = mx; i > 0; i--) begin
      longint co, cf, ce;
      co = ((rq * i) / fl) & 255;
      cf = (fl * co) / i;
      ce = (cf > rq) ? cf - rq : rq - cf;
      if (ce <= be) begin o = co; n = (i - co) & 255; f = cf; be = ce; end
    end
  endtask

  task automatic pulse_start(int rq, int fl, int mx);
    @(negedge clk);
    req_khz = 20'(rq); full_khz = 20'(fl); max_len = 8'(mx); start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done(string rq);
    int n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    chk({rq, " done seen"}, done, 1);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0); chk("R1 done", done, 0);
    chk("R1 off", off_cnt, 0); chk("R1 on", on_cnt, 0); chk("R1 ach", ach_khz, 0);
  endtask

  task automatic t_run(string tag, int rq, int fl, int mx);
    longint o, n, f;
    model(rq, fl, mx, o, n, f);
    pulse_start(rq, fl, mx);
    chk({tag, " R2 busy"}, busy, 1);
    wait_done(tag);
    chk({tag, " R2 busy low at done"}, busy, 0);
    chk({tag, " R3 off"}, off_cnt, o);
    chk({tag, " R3 on"}, on_cnt, n);
    chk({tag, " R4 ach"}, ach_khz, f);
    @(negedge clk);
    chk({tag, " R2 one-cycle done"}, done, 0);
  endtask

  task automatic t_tie();
    t_run("R5 tie", 100000, 200000, 4);
    chk("R5 shorter wins off", off_cnt, 1);
    chk("R5 shorter wins on", on_cnt, 1);
  endtask

  task automatic t_empty();
    pulse_start(1234, 90000, 0);
    chk("R6 done", done, 1);
    chk("R6 off", off_cnt, 1); chk("R6 on", on_cnt, 0); chk("R6 ach", ach_khz, 90000);
  endtask

  task automatic t_full();
    t_run("R7", 200000, 200000, 50);
    chk("R7 off", off_cnt, 1); chk("R7 on", on_cnt, 0); chk("R7 ach", ach_khz, 200000);
  endtask

  task automatic t_busy_start();
    longint o, n, f;
    model(47000, 133000, 40, o, n, f);
    pulse_start(47000, 133000, 40);
    repeat (300) @(negedge clk);
    pulse_start(9000, 300000, 3);
    req_khz = 5; full_khz = 7; max_len = 1;
    wait_done("R8");
    chk("R8 off", off_cnt, o); chk("R8 on", on_cnt, n); chk("R8 ach", ach_khz, f);
  endtask

  task automatic t_hold();
    logic [7:0] o, n; logic [19:0] f;
    o = off_cnt; n = on_cnt; f = ach_khz;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); req_khz = 20'(k * 977); full_khz = 20'(k * 3001 + 1); max_len = 8'(k);
    end
    chk("R9 off", off_cnt, o); chk("R9 on", on_cnt, n); chk("R9 ach", ach_khz, f);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_run("main a", 150000, 200000, 255);
    t_run("main b", 33333, 200000, 10);
    t_run("main c", 1000, 200000, 255);
    t_run("main d", 123456, 654321, 37);
    t_tie();
    t_empty();
    t_full();
    t_busy_start();
    t_hold();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule